// File: doc/BRIEF.md
# Frame-Checked Configuration Loader

This block takes a configuration image delivered as a word stream with a valid/ready handshake and writes it into a configuration memory. The image is cut into frames of a fixed number of data words. Each frame is followed by one check word, which is the CRC of that frame's data alone. The block runs the CRC over each frame as it arrives and holds the frame's words in a local buffer. It compares the result against the check word. Only a frame that passes is copied into the memory write port, one word per cycle, at addresses that continue from the previous frame.

When a frame fails its check, loading stops for good. The error flag rises and stays up until reset. The failing frame and everything after it are consumed but never written. When the stream ends cleanly, the block stores a final 32-bit reference value in a dedicated register for a runtime integrity checker that runs later. A word flagged as end of stream carries this value, and it arrives between frames. The block then raises its done flag.

Top module: `cfg_frame_loader`

## Requirements
- R1: After reset, in_ready is 1 and wr_en, load_done, load_err and ref_crc are all 0.
- R2: The frame CRC uses generator 0x04C11DB7. It is fed 32-bit words most significant bit first, starts from 0xFFFFFFFF at each frame, and has no bit reflection and no final inversion. The check word passes when it equals the CRC of the frame's FRAME_WORDS data words.
- R3: Between frames, a word with in_sof=1 is data word 0 of a new frame. FRAME_WORDS data words follow in order, and the check word comes after them. A word with neither in_sof nor in_eos that arrives between frames is discarded and produces no write.
- R4: A frame that passes is written with wr_en=1 on FRAME_WORDS consecutive cycles, in stream order. The addresses run consecutively from 0 for the first frame after reset and continue from where the previous frame ended.
- R5: in_ready is 0 exactly while a passed frame is being written out, and it is 1 in every other cycle.
- R6: On a check-word mismatch, load_err goes to 1 and stays at 1 until reset. No word of the failing frame or of any later frame is written, and in_ready stays 1 so that further input is accepted and discarded.
- R7: A word with in_eos=1 that arrives between frames loads its data into ref_crc and sets load_done, which stays at 1 until reset. After that, any further input is accepted without any write, and ref_crc does not change.
- R8: load_done and load_err are never 1 together. After an error, an end-of-stream word neither sets load_done nor changes ref_crc.
- R9: The in_sof and in_eos flags have no effect on data words 1 and later of a frame or on its check word. Those words are treated as frame content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | DATA_W | Stream word |
| in_sof | input | 1 | Marks the first data word of a frame |
| in_eos | input | 1 | Marks the end-of-stream word that carries the reference value |
| wr_en | output | 1 | Configuration memory write strobe |
| wr_addr | output | ADDR_W | Configuration memory write address |
| wr_data | output | DATA_W | Configuration memory write data |
| load_done | output | 1 | Stream ended with every frame passing |
| load_err | output | 1 | A frame failed its check (sticky) |
| ref_crc | output | 32 | Stored reference value for the runtime checker |

## Verification
The bench drives a frame whose check word has been corrupted. It expects no write from that frame or from any later one. A design that wrote data before checking, or that recovered after an error, would produce writes the scoreboard never queued. Frames with stray start and end markers on inner words and on the check word test R9. A design that honoured those markers would restart the frame or end the stream early, and a write would go missing. Junk words between frames and frames sent after done test R3 and R7, and a design that reacted to them would write at the wrong address or overwrite the stored reference. The bench computes its own CRC on every frame, so a wrong polynomial, bit order or seed turns a good frame into a false error.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    LD_SEEK   = 3'd0,
    LD_DATA   = 3'd1,
    LD_CHECK  = 3'd2,
    LD_COMMIT = 3'd3,
    LD_DONE   = 3'd4,
    LD_FAIL   = 3'd5
  } ld_state_t;

endpackage

// File: rtl/cfg_crc32_step.sv
module cfg_crc32_step
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       crc_in,
  input  logic [DATA_W-1:0] word_in,
  output logic [31:0]       crc_out
);

  // Bit-serial shift of one full word, most significant bit first.
  always_comb begin
    logic [31:0] acc;
    logic        fb;
    acc = crc_in;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb  = acc[31] ^ word_in[b];
      acc = {acc[30:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    crc_out = acc;
  end

endmodule

// File: rtl/cfg_frame_buffer.sv
module cfg_frame_buffer #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_WORDS = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eos,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              load_done,
  output logic              load_err,
  output logic [31:0]       ref_crc
);

  localparam int CNT_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(FRAME_WORDS - 1);
  localparam logic [ADDR_W-1:0] FRAME_STEP = ADDR_W'(FRAME_WORDS);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // State
  ld_state_t         state_q, state_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [31:0]       crc_q, crc_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [31:0]       ref_q, ref_d;
  logic              crc_en, idx_en, base_en, ref_en;

  logic              accept;
  logic              buf_we;
  logic [31:0]       crc_src, crc_step;
  logic [DATA_W-1:0] buf_rdata;

  assign in_ready = (state_q != LD_COMMIT);
  assign accept   = in_valid && in_ready;

  // A new frame starts from the seed; later words chain from the running value.
  assign crc_src = (state_q == LD_SEEK) ? CRC_SEED : crc_q;

  cfg_crc32_step #(.DATA_W(DATA_W)) u_crc (
    .crc_in  (crc_src),
    .word_in (in_data),
    .crc_out (crc_step)
  );

  cfg_frame_buffer #(.DEPTH(FRAME_WORDS), .DATA_W(DATA_W)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (idx_q),
    .wdata (in_data),
    .raddr (idx_q),
    .rdata (buf_rdata)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    crc_d   = crc_q;
    base_d  = base_q;
    ref_d   = ref_q;
    crc_en  = 1'b0;
    idx_en  = 1'b0;
    base_en = 1'b0;
    ref_en  = 1'b0;
    buf_we  = 1'b0;
    unique case (state_q)
      LD_SEEK: begin
        if (accept) begin
          if (in_eos) begin
            ref_d   = in_data[31:0];
            ref_en  = 1'b1;
            state_d = LD_DONE;
          end else if (in_sof) begin
            buf_we  = 1'b1;
            crc_d   = crc_step;
            crc_en  = 1'b1;
            if (idx_q == LAST_IDX) begin
              state_d = LD_CHECK;
            end else begin
              idx_d   = idx_q + CNT_W'(1);
              idx_en  = 1'b1;
              state_d = LD_DATA;
            end
          end
        end
      end
      LD_DATA: begin
        if (accept) begin
          buf_we = 1'b1;
          crc_d  = crc_step;
          crc_en = 1'b1;
          if (idx_q == LAST_IDX) begin
            state_d = LD_CHECK;
          end else begin
            idx_d  = idx_q + CNT_W'(1);
            idx_en = 1'b1;
          end
        end
      end
      LD_CHECK: begin
        if (accept) begin
          idx_d  = '0;
          idx_en = 1'b1;
          if (in_data[31:0] == crc_q) state_d = LD_COMMIT;
          else                        state_d = LD_FAIL;
        end
      end
      LD_COMMIT: begin
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          base_d  = base_q + FRAME_STEP;
          base_en = 1'b1;
          state_d = LD_SEEK;
        end else begin
          idx_d = idx_q + CNT_W'(1);
        end
        idx_en = 1'b1;
      end
      LD_DONE, LD_FAIL: begin
        state_d = state_q;
      end
      default: state_d = LD_FAIL;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= LD_SEEK;
      idx_q   <= '0;
      crc_q   <= '0;
      base_q  <= '0;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx_q  <= idx_d;
      if (crc_en)  crc_q  <= crc_d;
      if (base_en) base_q <= base_d;
      if (ref_en)  ref_q  <= ref_d;
    end
  end

  assign wr_en     = (state_q == LD_COMMIT);
  assign wr_addr   = base_q + ADDR_W'(idx_q);
  assign wr_data   = buf_rdata;
  assign load_done = (state_q == LD_DONE);
  assign load_err  = (state_q == LD_FAIL);
  assign ref_crc   = ref_q;

  // Assertions
  assert_commit_follows_check_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wr_en) |-> $past(state_q) == LD_CHECK);

  assert_addr_consecutive_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + ADDR_W'(1));

  assert_ready_only_idle_in_commit_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == LD_CHECK && accept && in_data[31:0] == crc_q) |=> !in_ready);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_err |=> load_err && in_ready);

  assert_no_write_after_err_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_err |-> !wr_en);

  assert_ref_held_after_done_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_done |=> load_done && $stable(ref_crc) && !wr_en);

  assert_done_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(load_done && load_err));

  assert_ref_zero_until_done_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_err |=> $stable(ref_crc));

endmodule

// File: tb/cfg_frame_loader_test.sv
`timescale 1ns/1ps
module cfg_frame_loader_test;

  localparam int FW = 16;
  localparam int DW = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          in_sof;
  logic          in_eos;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          load_done;
  logic          load_err;
  logic [31:0]   ref_crc;

  always #2.5 clk = ~clk;

  cfg_frame_loader #(.FRAME_WORDS(FW), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eos(in_eos), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_done(load_done),
    .load_err(load_err), .ref_crc(ref_crc)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_item_t;

  wr_item_t  exp_q[$];
  int        checks = 0;
  int        errors = 0;
  int        next_addr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] != w[b]) r = (r << 1) ^ 32'h04C1_1DB7;
      else               r = r << 1;
    end
    return r;
  endfunction

  task automatic put(input logic [DW-1:0] d, input bit sof, input bit eos);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = sof;
    in_eos   = eos;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eos   = 1'b0;
  endtask

  // Sends one frame; expect_wr pushes the scoreboard items for a passing frame.
  // stray puts start/end markers on inner words and on the check word (R9).
  task automatic send_frame(input int seed, input bit corrupt, input bit stray,
                            input bit expect_wr);
    logic [31:0] c;
    logic [DW-1:0] w;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < FW; i++) begin
      w = DW'(seed) * 32'h9E37_79B1 + DW'(i) * 32'h0101_0F0F;
      c = model_crc(c, w);
      if (expect_wr) begin
        exp_q.push_back('{addr: AW'(next_addr + i), data: w});
      end
      put(w, (i == 0) || (stray && i == 3), stray && (i == 5));
    end
    if (expect_wr) next_addr += FW;
    put(corrupt ? (c ^ 32'h0000_0100) : c, stray, stray);
  endtask

  task automatic settle();
    repeat (FW + 4) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected write", {20'h0, wr_addr, wr_data}, 64'h0);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        check(wr_addr == e.addr, "R4", "write address", 64'(wr_addr), 64'(e.addr));
        check(wr_data == e.data, "R2", "write data", 64'(wr_data), 64'(e.data));
      end
      check(in_ready == 1'b0, "R5", "ready during commit", 64'(in_ready), 64'h0);
    end
  end

  task automatic do_reset();
    in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eos = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_q.delete();
    next_addr = 0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'h1);
    check(wr_en == 1'b0, "R1", "wr_en after reset", 64'(wr_en), 64'h0);
    check(load_done == 1'b0 && load_err == 1'b0, "R1", "flags after reset",
          64'({load_done, load_err}), 64'h0);
    check(ref_crc == 32'h0, "R1", "ref after reset", 64'(ref_crc), 64'h0);

    // R2/R4 plain passing frame
    send_frame(1, 1'b0, 1'b0, 1'b1);
    settle();
    check(exp_q.size() == 0, "R4", "frame 1 fully written", 64'(exp_q.size()), 64'h0);
    check(load_err == 1'b0, "R2", "good frame not flagged", 64'(load_err), 64'h0);

    // R3 junk word between frames is dropped
    put(32'hDEAD_BEEF, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && !load_err, "R3", "junk word dropped", 64'({in_ready, load_err}), 64'h2);

    // R9 stray markers inside the frame
    send_frame(2, 1'b0, 1'b1, 1'b1);
    settle();
    check(exp_q.size() == 0, "R9", "frame with stray flags written", 64'(exp_q.size()), 64'h0);
    check(!load_done && !load_err, "R9", "no early end", 64'({load_done, load_err}), 64'h0);

    send_frame(3, 1'b0, 1'b0, 1'b1);
    settle();
    check(exp_q.size() == 0, "R4", "frame 3 fully written", 64'(exp_q.size()), 64'h0);

    // R7 end of stream
    put(32'hCAFE_F00D, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    check(load_done == 1'b1, "R7", "done set", 64'(load_done), 64'h1);
    check(ref_crc == 32'hCAFE_F00D, "R7", "reference stored", 64'(ref_crc), 64'hCAFE_F00D);
    check(load_err == 1'b0, "R8", "no error with done", 64'(load_err), 64'h0);

    // R7 input after done is discarded
    send_frame(4, 1'b0, 1'b0, 1'b0);
    put(32'h1234_5678, 1'b0, 1'b1);
    settle();
    check(ref_crc == 32'hCAFE_F00D, "R7", "reference held", 64'(ref_crc), 64'hCAFE_F00D);
    check(load_done == 1'b1, "R7", "done held", 64'(load_done), 64'h1);

    // Error run
    do_reset();
    send_frame(5, 1'b0, 1'b0, 1'b1);
    settle();
    check(exp_q.size() == 0, "R4", "restart address 0 frame", 64'(exp_q.size()), 64'h0);
    send_frame(6, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(load_err == 1'b1, "R6", "error on mismatch", 64'(load_err), 64'h1);
    check(in_ready == 1'b1, "R6", "ready after error", 64'(in_ready), 64'h1);
    send_frame(7, 1'b0, 1'b0, 1'b0);
    put(32'hAAAA_5555, 1'b0, 1'b1);
    settle();
    check(load_err == 1'b1, "R6", "error sticky", 64'(load_err), 64'h1);
    check(load_done == 1'b0, "R8", "no done after error", 64'(load_done), 64'h0);
    check(ref_crc == 32'h0, "R8", "reference untouched after error", 64'(ref_crc), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule